// File: doc/BRIEF.md
# Multichannel I/Q Downconverter with Serialized Comb

This block turns several coherently sampled ADC streams into decimated baseband I/Q pairs. An internal oscillator steps through a 33-point cosine/sine table. It advances 7 points per sample, so its tone sits at 7/33 of the sample rate. That is the ratio of a 20 MHz IF sampled at 94.3 MS/s. Each channel's samples are multiplied by both oscillator outputs. Each of the resulting I and Q products then feeds its own chain of CIC integrators, which run on every clock.

Every R cycles, where R is the decimation setting, the integrator outputs are copied into a shift chain. The chain feeds one comb section that all channels share. The comb works on one word per cycle. It keeps a rotating delay line per stage, so each word is differenced against its own value from the previous frame. The result is a burst of tagged words, one per cycle, that a later amplitude/phase converter can consume.

Top module: `dcv_downconv`

## Requirements
- R1: The oscillator phase starts at table index 0 after reset and advances by 7 modulo 33 on every clock. A tone at 7/33 of the sample rate therefore mixes exactly to DC.
- R2: The I product is the sample times the cosine entry and the Q product is the sample times the sine entry, both arithmetically shifted right by LW-1. For an input of A·cos(θ+φ), the I product averages to +A/2·cos φ and the Q product averages to −A/2·sin φ.
- R3: Each product has its own CIC_N-stage integrator chain, clocked every cycle. The integrators wrap in two's complement, so results stay correct after long runs in which the integrators overflow.
- R4: With R a multiple of 33, the steady decimated I and Q values equal R^CIC_N times the per-sample mean, within 1 % of R^CIC_N·A/2 plus R^CIC_N counts.
- R5: Once per decimation period, exactly 2·NCH valid words appear on consecutive cycles. Successive first words of a burst are R_eff cycles apart.
- R6: Within a burst the words are ordered as channel 0 I, channel 0 Q, channel 1 I, and so on. The channel number is given on out_ch_o, and out_q_o is 0 for I and 1 for Q.
- R7: The effective decimation R_eff is dec_i clamped to the range [2·NCH, 256]. A setting of 1 gives a burst spacing of 2·NCH, and a setting of 300 gives a spacing of 256.
- R8: A channel whose input is zero produces I and Q outputs of exactly zero, whatever the other channels carry.
- R9: A synchronous active-high reset clears the oscillator phase, the integrators, the shift chain and the comb delays. While reset is held, out_valid_o and out_data_o are 0.
- R10: A new decimation setting takes effect at a burst boundary. A running burst is never cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one ADC sample per channel per cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| dec_i | input | 9 | Requested decimation factor |
| adc_i | input | NCH·DW (28) | Signed ADC samples; channel k in bits k·DW +: DW |
| out_valid_o | output | 1 | Qualifies one output word |
| out_ch_o | output | CHW (1) | Channel number of the word |
| out_q_o | output | 1 | 0 = I, 1 = Q |
| out_data_o | output | AW (31) | Signed decimated value |

## Verification
The bench drives coherent tones with known amplitude and phase at two decimation factors. Swapped cosine and sine tables, a wrong Q sign or a wrong phase step would move the settled I/Q values far outside tolerance. With one channel held at zero, any mixing of channels inside the shared comb shows up as a nonzero word. A comb delay line that is not aligned per word gives garbage values instead. The clamp cases (settings 1 and 300) and a non-multiple setting of 10 check burst spacing, word order and burst length. A counter that compared against the raw setting, or a belt that skipped or repeated a word, would change the measured gap or the order of the tags.

// File: rtl/dcv_pkg.sv
package dcv_pkg;
    localparam int NCH     = 2;
    localparam int DW      = 14;
    localparam int LW      = 16;
    localparam int CIC_N   = 2;
    localparam int RLOG    = 8;
    localparam int PH_MOD  = 33;
    localparam int PH_STEP = 7;

    localparam int RMAX = 1 << RLOG;
    localparam int DECW = RLOG + 1;
    localparam int PW   = DW + 1;
    localparam int AW   = PW + CIC_N * RLOG;
    localparam int NW   = 2 * NCH;
    localparam int TAGW = $clog2(NW);
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int PHW  = $clog2(PH_MOD);

    localparam longint UNIT_CIRC = 360 * PH_MOD;
    localparam longint UNIT_HALF = 180 * PH_MOD;
    localparam longint UNIT_QRT  = 90 * PH_MOD;
    localparam longint BH_DEN    = 40500 * PH_MOD * PH_MOD;
    localparam longint LO_AMP    = (1 << (LW - 1)) - 1;

    typedef logic signed [AW-1:0] acc_t;
    typedef logic signed [LW-1:0] lo_t;

    typedef struct packed {
        logic [CHW-1:0] ch;
        logic           q;
        acc_t           val;
    } word_t;

    // rational sine approximation on the positive half cycle
    function automatic longint half_sine(longint b);
        longint p;
        p = b * (UNIT_HALF - b);
        return (4 * p * LO_AMP + (BH_DEN - p) / 2) / (BH_DEN - p);
    endfunction

    // table entry: quad=1 sine, quad=0 cosine
    function automatic int lo_entry(int idx, bit quad);
        longint a;
        a = (longint'(idx) * 360 + (quad ? 0 : UNIT_QRT)) % UNIT_CIRC;
        if (a <= UNIT_HALF) return int'(half_sine(a));
        return -int'(half_sine(a - UNIT_HALF));
    endfunction
endpackage

// File: rtl/dcv_lo.sv
module dcv_lo
    import dcv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output lo_t  cos_o,
    output lo_t  sin_o
);
    logic [PHW-1:0] ph;
    lo_t cos_rom [PH_MOD];
    lo_t sin_rom [PH_MOD];

    for (genvar k = 0; k < PH_MOD; k++) begin : g_rom
        assign cos_rom[k] = LW'(lo_entry(k, 1'b0));
        assign sin_rom[k] = LW'(lo_entry(k, 1'b1));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            ph <= '0;
        else if (ph >= PHW'(PH_MOD - PH_STEP))
            ph <= ph - PHW'(PH_MOD - PH_STEP);
        else
            ph <= ph + PHW'(PH_STEP);
    end

    assign cos_o = cos_rom[ph];
    assign sin_o = sin_rom[ph];
endmodule

// File: rtl/dcv_integ.sv
module dcv_integ
    import dcv_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic signed [PW-1:0] prod_i,
    output acc_t                 acc_o
);
    acc_t st [CIC_N];

    always_ff @(posedge clk_i) begin
        if (rst_i) st[0] <= '0;
        else       st[0] <= st[0] + AW'(prod_i);
    end

    for (genvar s = 1; s < CIC_N; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i) st[s] <= '0;
            else       st[s] <= st[s] + st[s-1];
        end
    end

    assign acc_o = st[CIC_N-1];
endmodule

// File: rtl/dcv_belt.sv
module dcv_belt
    import dcv_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [DECW-1:0]    dec_i,
    input  acc_t [NW-1:0]      integ_i,
    output logic               valid_o,
    output word_t              word_o
);
    logic [DECW-1:0] r_eff;
    logic [DECW-1:0] dcnt;
    logic [TAGW-1:0] idx;
    logic            busy;
    logic            last;
    logic            tick;
    acc_t            chain [NW];

    always_comb begin
        if (dec_i < DECW'(NW))        r_eff = DECW'(NW);
        else if (dec_i > DECW'(RMAX)) r_eff = DECW'(RMAX);
        else                          r_eff = dec_i;
    end

    assign last = busy && (idx == TAGW'(NW - 1));
    assign tick = (dcnt >= r_eff - 1'b1) && (!busy || last);

    always_ff @(posedge clk_i) begin
        if (rst_i)     dcnt <= '0;
        else if (tick) dcnt <= '0;
        else           dcnt <= dcnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy <= 1'b0;
            idx  <= '0;
            for (int k = 0; k < NW; k++) chain[k] <= '0;
        end else if (tick) begin
            busy <= 1'b1;
            idx  <= '0;
            for (int k = 0; k < NW; k++) chain[k] <= integ_i[k];
        end else if (busy) begin
            idx  <= idx + 1'b1;
            busy <= !last;
            for (int k = 0; k < NW - 1; k++) chain[k] <= chain[k+1];
            chain[NW-1] <= '0;
        end
    end

    assign valid_o    = busy;
    assign word_o.val = chain[0];
    assign word_o.ch  = CHW'(idx >> 1);
    assign word_o.q   = idx[0];
endmodule

// File: rtl/dcv_comb_stage.sv
module dcv_comb_stage
    import dcv_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  valid_i,
    input  word_t word_i,
    output logic  valid_o,
    output word_t word_o
);
    acc_t dly [NW];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_o <= 1'b0;
            word_o  <= '0;
            for (int k = 0; k < NW; k++) dly[k] <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                word_o.val <= word_i.val - dly[0];
                word_o.ch  <= word_i.ch;
                word_o.q   <= word_i.q;
                for (int k = 0; k < NW - 1; k++) dly[k] <= dly[k+1];
                dly[NW-1] <= word_i.val;
            end
        end
    end
endmodule

// File: rtl/dcv_downconv.sv
module dcv_downconv
    import dcv_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [DECW-1:0]     dec_i,
    input  logic [NCH*DW-1:0]   adc_i,
    output logic                out_valid_o,
    output logic [CHW-1:0]      out_ch_o,
    output logic                out_q_o,
    output logic [AW-1:0]       out_data_o
);
    localparam int FW = DW + LW;

    lo_t          lo_cos, lo_sin;
    acc_t [NW-1:0] integ;
    logic         cv [CIC_N+1];
    word_t        cw [CIC_N+1];

    dcv_lo u_lo (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cos_o (lo_cos),
        .sin_o (lo_sin)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [DW-1:0] smp;
        logic signed [FW-1:0] full_i, full_q;
        logic signed [PW-1:0] prod_i, prod_q;

        assign smp    = $signed(adc_i[c*DW +: DW]);
        assign full_i = smp * lo_cos;
        assign full_q = smp * lo_sin;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                prod_i <= '0;
                prod_q <= '0;
            end else begin
                prod_i <= full_i[FW-1 -: PW];
                prod_q <= full_q[FW-1 -: PW];
            end
        end

        dcv_integ u_int_i (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .prod_i (prod_i),
            .acc_o  (integ[2*c])
        );
        dcv_integ u_int_q (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .prod_i (prod_q),
            .acc_o  (integ[2*c+1])
        );
    end

    dcv_belt u_belt (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .dec_i   (dec_i),
        .integ_i (integ),
        .valid_o (cv[0]),
        .word_o  (cw[0])
    );

    for (genvar s = 0; s < CIC_N; s++) begin : g_comb
        dcv_comb_stage u_stage (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .valid_i (cv[s]),
            .word_i  (cw[s]),
            .valid_o (cv[s+1]),
            .word_o  (cw[s+1])
        );
    end

    assign out_valid_o = cv[CIC_N];
    assign out_ch_o    = cw[CIC_N].ch;
    assign out_q_o     = cw[CIC_N].q;
    assign out_data_o  = cw[CIC_N].val;
endmodule

// File: rtl/dcv_checker.sv
module dcv_checker
    import dcv_pkg::*;
(
    input logic           clk_i,
    input logic           rst_i,
    input logic           out_valid_o,
    input logic [CHW-1:0] out_ch_o,
    input logic           out_q_o
);
    logic [TAGW:0] tag;
    assign tag = (TAGW+1)'(out_ch_o) * 2 + (TAGW+1)'(out_q_o);

    // R6: consecutive words step through the tags in order
    p_tag_step_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && $past(out_valid_o) && !$past(rst_i)) |->
        ((tag == $past(tag) + 1'b1) ||
         ($past(tag) == (TAGW+1)'(NW - 1) && tag == '0)));

    // R6: a burst opens with channel 0 I
    p_burst_start_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(out_valid_o) && !$past(rst_i)) |-> (tag == '0));

    // R5, R10: a burst only ends after its last word
    p_burst_whole_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(out_valid_o) && !$past(rst_i)) |->
        ($past(tag) == (TAGW+1)'(NW - 1)));

    // R9: nothing valid right after reset
    p_reset_quiet_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !out_valid_o);
endmodule

bind dcv_downconv dcv_checker i_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .out_valid_o (out_valid_o),
    .out_ch_o    (out_ch_o),
    .out_q_o     (out_q_o)
);

// File: tb/test_dcv_downconv.sv
module test_dcv_downconv;
    import dcv_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [DECW-1:0]     dec = DECW'(33);
    logic [NCH*DW-1:0]   adc = '0;
    logic                out_valid;
    logic [CHW-1:0]      out_ch;
    logic                out_q;
    logic [AW-1:0]       out_data;

    real amp [NCH];
    real phs [NCH];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    longint cyc = 0, last0 = 0, gap = 0;
    int     frames = 0, run = 0, last_run = 0, order_err = 0, exp_idx = 0;
    logic signed [AW-1:0] cap [NW];

    always #10 clk = ~clk;

    dcv_downconv i_dcv_downconv (
        .clk_i       (clk),
        .rst_i       (rst),
        .dec_i       (dec),
        .adc_i       (adc),
        .out_valid_o (out_valid),
        .out_ch_o    (out_ch),
        .out_q_o     (out_q),
        .out_data_o  (out_data)
    );

    function automatic int tone(real a, real p, longint n);
        return int'(a * $cos(2.0 * 3.141592653589793 * real'(PH_STEP)
                             * real'(n % PH_MOD) / real'(PH_MOD) + p));
    endfunction

    // stimulus: sample n meets oscillator index 7n mod 33 (R1)
    initial begin
        longint n = 0;
        for (int c = 0; c < NCH; c++) begin amp[c] = 0.0; phs[c] = 0.0; end
        forever begin
            @(posedge clk);
            #1;
            if (rst) n = 0; else n = n + 1;
            for (int c = 0; c < NCH; c++)
                adc[c*DW +: DW] = DW'(tone(amp[c], phs[c], n));
        end
    end

    // output monitor
    initial begin
        for (int k = 0; k < NW; k++) cap[k] = '0;
        forever begin
            int idx;
            @(negedge clk);
            cyc = cyc + 1;
            if (rst) begin
                run = 0; exp_idx = 0;
            end else if (out_valid) begin
                idx = int'(out_ch) * 2 + int'(out_q);
                if (idx != exp_idx) order_err = order_err + 1;
                exp_idx = (idx + 1) % NW;
                cap[idx] = out_data;
                if (idx == 0) begin gap = cyc - last0; last0 = cyc; end
                run = run + 1;
                if (idx == NW - 1) frames = frames + 1;
            end else begin
                if (run > 0) last_run = run;
                run = 0; exp_idx = 0;
            end
        end
    end

    task automatic chk_int(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_near(string req, real act, real exp, real tol);
        n_cmp++;
        if (act > exp + tol || act < exp - tol) begin
            n_bad++;
            $display("FAIL %s: actual %0.1f expected %0.1f (tol %0.1f)", req, act, exp, tol);
        end
    endtask

    task automatic wait_frames(int k);
        int f0 = frames;
        while (frames < f0 + k) @(negedge clk);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic check_tone(string req, int r);
        real g = real'(r) ** CIC_N;
        for (int c = 0; c < NCH; c++) begin
            real ei = g * amp[c] / 2.0 * $cos(phs[c]);
            real eq = -g * amp[c] / 2.0 * $sin(phs[c]);
            real tol = 0.01 * g * amp[c] / 2.0 + g;
            if (amp[c] == 0.0) begin
                chk_int({req, " R8 zero ch I"}, longint'(cap[2*c]), 0);
                chk_int({req, " R8 zero ch Q"}, longint'(cap[2*c+1]), 0);
            end else begin
                chk_near({req, " I"}, real'(longint'(cap[2*c])), ei, tol);
                chk_near({req, " Q"}, real'(longint'(cap[2*c+1])), eq, tol);
            end
        end
    endtask

    // R9: reset state
    task automatic t_reset;
        @(negedge clk);
        chk_int("R9 valid in reset", longint'(out_valid), 0);
        chk_int("R9 data in reset", longint'(out_data), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk_int("R9 quiet after reset", longint'(out_valid), 0);
    endtask

    // R1 R2 R3 R4 R8: one tone, one silent channel, R = 33
    task automatic t_tone_33;
        amp[0] = 6000.0; phs[0] = 0.6;
        amp[1] = 0.0;    phs[1] = 0.0;
        dec = DECW'(33);
        wait_frames(40);
        check_tone("R4 R2 R1 R3 dec33", 33);
    endtask

    // R2 R3 R4: two tones, other phases, R = 66
    task automatic t_tone_66;
        amp[0] = 3000.0; phs[0] = -2.0;
        amp[1] = 7000.0; phs[1] = 2.5;
        dec = DECW'(66);
        wait_frames(6);
        check_tone("R4 R2 dec66", 66);
    endtask

    // R5 R6 R10: spacing, burst length, order at R = 10
    task automatic t_order;
        int e0;
        dec = DECW'(10);
        wait_frames(3);
        e0 = order_err;
        wait_frames(4);
        chk_int("R5 burst spacing", gap, 10);
        chk_int("R5 burst length", longint'(last_run), NW);
        chk_int("R6 R10 word order", longint'(order_err - e0), 0);
    endtask

    // R7: clamp at both ends
    task automatic t_clamp;
        dec = DECW'(1);
        wait_frames(4);
        chk_int("R7 low clamp spacing", gap, NW);
        dec = DECW'(300);
        wait_frames(3);
        chk_int("R7 high clamp spacing", gap, RMAX);
    endtask

    // R9: reset during operation
    task automatic t_reset_mid;
        dec = DECW'(33);
        wait_frames(1);
        repeat (16) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk_int("R9 valid mid reset", longint'(out_valid), 0);
        chk_int("R9 data mid reset", longint'(out_data), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_tone_33();
        t_tone_66();
        t_order();
        t_clamp();
        t_reset_mid();
        summary();
    end
endmodule